// File: doc/BRIEF.md
# Addressable RGB LED Chain Driver

This block sends colour data to a daisy chain of single-wire RGB LEDs over one output pin. A sequencer walks through a low reset gap, then through every LED of the chain and every bit of that LED's 24-bit colour word. For each clock it hands a small token to a waveform stage. The token either marks the gap or names the LED index, the bit position and the cycle count reached inside the current bit slot.

The waveform stage replaces the LED index with a colour taken from a fixed four-entry palette. It picks out the current bit and drives the pin high for a short or a long pulse, depending on that bit. All pulse widths are inputs, given in clock cycles: the product of the clock frequency and the wanted time. At 100 MHz these are 28000 for the gap, 125 for the bit slot, 40 for a zero's pulse and 80 for a one's pulse. The number of LEDs in the chain is also an input. A frame repeats forever: gap, LED 0, LED 1, and so on, then gap again.

Top module: `rgb_chain_driver`

## Requirements
- R1: While `rst` is high the pin is low and the sequencer sits in the gap with its counters cleared. From the first edge after `rst` falls, the pin stays low for exactly `gapCycles` cycles before the first high pulse.
- R2: A data bit of value 0 drives the pin high for `zeroHighCycles` cycles, then low for the remainder of the bit slot.
- R3: A data bit of value 1 drives the pin high for `oneHighCycles` cycles, then low for the remainder of the bit slot.
- R4: Every bit slot that is not the last one of a frame lasts exactly `bitCycles` cycles, counted from one rising edge of the pin to the next.
- R5: Each LED's colour is sent as the 24-bit word {G[7:0], R[7:0], B[7:0]}, starting with bit 23 (G[7]) and ending with bit 0 (B[0]).
- R6: In a frame the LEDs are sent in increasing index order, from 0 to `ledCount`-1, with 24 bits each.
- R7: The palette maps LED index 0 to (R,G,B) = (64,0,0), index 1 to (0,64,0), index 2 to (0,0,64) and index 3 to (0,64,64).
- R8: After the last bit of the last LED the pin stays low for the rest of that bit slot plus `gapCycles` cycles. The next frame then starts again at LED 0.
- R9: With `ledCount` = 0 the pin never goes high. The block stays in the gap indefinitely.
- R10: The timing inputs and `ledCount` (1 to 4) are applied as given at run time, so the same netlist works for any clock frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ledCount | input | 3 | Number of LEDs in the chain, 0 to 4 |
| gapCycles | input | 16 | Length of the low reset gap in cycles |
| bitCycles | input | 16 | Length of one bit slot in cycles |
| zeroHighCycles | input | 16 | High time of a 0 bit in cycles |
| oneHighCycles | input | 16 | High time of a 1 bit in cycles |
| ledOut | output | 1 | Serial data pin to the first LED |

## Verification
The bench measures every high and low run on the pin and turns the runs back into bits, so encoding faults and ordering faults show up as separate mismatches. It runs the full 100 MHz timing with two LEDs, where the palette's single set bits mostly tell apart channel order and MSB-first order. A short timing with four LEDs exercises every palette entry and two frames in a row, which separates a correct restart at LED 0 from one that carries on. A single-LED chain catches off-by-one errors in the last-LED test. An empty chain confirms that the gap never ends.

// File: rtl/rgbdrv_pkg.sv
package rgbdrv_pkg;
  localparam int IDX_W     = 2;             // LED index width
  localparam int NUM_PAL   = 1 << IDX_W;    // palette entries
  localparam int CNT_W     = 16;            // timing counter width
  localparam int CH_W      = 8;             // bits per colour channel
  localparam int WORD_W    = 3 * CH_W;      // bits per LED
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int LEDCNT_W  = IDX_W + 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [CH_W-1:0]  LEVEL    = CH_W'(64);

  // Token passed from the sequencer to the waveform stage.
  typedef struct packed {
    logic             isLed;   // 0: reset gap, 1: LED bit
    logic [IDX_W-1:0] ledIdx;
    logic [BIT_W-1:0] bitIdx;  // 0 = first bit sent (MSB of the word)
    logic [CNT_W-1:0] dur;     // cycles already spent in this slot
  } ledToken_t;

  // Colour word {G,R,B} for a palette slot.
  function automatic logic [WORD_W-1:0] paletteGrb(input logic [IDX_W-1:0] idx);
    logic [CH_W-1:0] r, g, b;
    r = '0; g = '0; b = '0;
    case (idx)
      2'd0: r = LEVEL;
      2'd1: g = LEVEL;
      2'd2: b = LEVEL;
      default: begin g = LEVEL; b = LEVEL; end
    endcase
    return {g, r, b};
  endfunction
endpackage

// File: rtl/rgbdrv_seq.sv
module rgbdrv_seq
  import rgbdrv_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [LEDCNT_W-1:0] ledCount,
  input  logic [CNT_W-1:0]    gapCycles,
  input  logic [CNT_W-1:0]    bitCycles,
  output ledToken_t           tok
);
  logic             isLed;
  logic [IDX_W-1:0] ledIdx;
  logic [BIT_W-1:0] bitIdx;
  logic [CNT_W-1:0] dur;

  logic slotEnd, gapEnd, lastLed;
  logic [LEDCNT_W-1:0] nextLedNum;

  assign slotEnd    = (dur >= bitCycles - CNT_W'(1));
  assign gapEnd     = (dur >= gapCycles - CNT_W'(1));
  assign nextLedNum = {1'b0, ledIdx} + LEDCNT_W'(1);
  assign lastLed    = (nextLedNum >= ledCount);

  always_ff @(posedge clk) begin
    if (rst) begin
      isLed  <= 1'b0;
      ledIdx <= '0;
      bitIdx <= '0;
      dur    <= '0;
    end else if (!isLed) begin
      if (gapEnd) begin
        dur <= '0;
        if (ledCount != '0) begin
          isLed  <= 1'b1;
          ledIdx <= '0;
          bitIdx <= '0;
        end
      end else begin
        dur <= dur + CNT_W'(1);
      end
    end else begin
      if (slotEnd) begin
        dur <= '0;
        if (bitIdx == LAST_BIT) begin
          bitIdx <= '0;
          if (lastLed) begin
            isLed  <= 1'b0;
            ledIdx <= '0;
          end else begin
            ledIdx <= ledIdx + IDX_W'(1);
          end
        end else begin
          bitIdx <= bitIdx + BIT_W'(1);
        end
      end else begin
        dur <= dur + CNT_W'(1);
      end
    end
  end

  assign tok = '{isLed: isLed, ledIdx: ledIdx, bitIdx: bitIdx, dur: dur};

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bitIdx <= LAST_BIT); // R5
  AST_FRAME_START: assert property (@(posedge clk) disable iff (rst)
    $rose(isLed) |-> (ledIdx == '0 && bitIdx == '0)); // R6
  AST_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (isLed && dur == bitCycles - CNT_W'(1) && bitIdx != LAST_BIT)
      |=> (bitIdx == $past(bitIdx) + BIT_W'(1))); // R4
  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (isLed && dur == bitCycles - CNT_W'(1) && bitIdx == LAST_BIT
      && nextLedNum == ledCount) |=> !isLed); // R8
  AST_EMPTY_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (ledCount == '0 && !isLed) |=> !isLed); // R9
endmodule

// File: rtl/rgbdrv_wave.sv
module rgbdrv_wave
  import rgbdrv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ledToken_t        tok,
  input  logic [CNT_W-1:0] zeroHighCycles,
  input  logic [CNT_W-1:0] oneHighCycles,
  output logic             pinOut
);
  logic [WORD_W-1:0] colorWord;
  logic [BIT_W-1:0]  wordPos;
  logic              curBit;
  logic [CNT_W-1:0]  highLen;
  logic              driveHigh;

  // Index replaced by colour; bit position and duration pass through.
  assign colorWord = paletteGrb(tok.ledIdx);
  assign wordPos   = LAST_BIT - tok.bitIdx;
  assign curBit    = colorWord[wordPos];
  assign highLen   = curBit ? oneHighCycles : zeroHighCycles;
  assign driveHigh = tok.isLed && (tok.dur < highLen);

  always_ff @(posedge clk) begin
    if (rst) pinOut <= 1'b0;
    else     pinOut <= driveHigh;
  end

  AST_GAP_LOW: assert property (@(posedge clk) disable iff (rst)
    !tok.isLed |=> !pinOut); // R8
  AST_HIGH_NEEDS_LED: assert property (@(posedge clk) disable iff (rst)
    pinOut |-> $past(tok.isLed)); // R2
  AST_SLOT_START_HIGH: assert property (@(posedge clk) disable iff (rst)
    (tok.isLed && tok.dur == '0 && zeroHighCycles != '0 && oneHighCycles != '0)
      |=> pinOut); // R3
endmodule

// File: rtl/rgb_chain_driver.sv
module rgb_chain_driver
  import rgbdrv_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [LEDCNT_W-1:0] ledCount,
  input  logic [CNT_W-1:0]    gapCycles,
  input  logic [CNT_W-1:0]    bitCycles,
  input  logic [CNT_W-1:0]    zeroHighCycles,
  input  logic [CNT_W-1:0]    oneHighCycles,
  output logic                ledOut
);
  ledToken_t tok;

  rgbdrv_seq uSeq (
    .clk       (clk),
    .rst       (rst),
    .ledCount  (ledCount),
    .gapCycles (gapCycles),
    .bitCycles (bitCycles),
    .tok       (tok)
  );

  rgbdrv_wave uWave (
    .clk            (clk),
    .rst            (rst),
    .tok            (tok),
    .zeroHighCycles (zeroHighCycles),
    .oneHighCycles  (oneHighCycles),
    .pinOut         (ledOut)
  );
endmodule

// File: tb/rgb_chain_driver_test.sv
`timescale 1ns/1ps
module rgb_chain_driver_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ledCount = 3'd2;
  logic [15:0] gapCycles = 16'd28000;
  logic [15:0] bitCycles = 16'd125;
  logic [15:0] zeroHighCycles = 16'd40;
  logic [15:0] oneHighCycles = 16'd80;
  logic        ledOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  rgb_chain_driver uut (
    .clk(clk), .rst(rst), .ledCount(ledCount), .gapCycles(gapCycles),
    .bitCycles(bitCycles), .zeroHighCycles(zeroHighCycles),
    .oneHighCycles(oneHighCycles), .ledOut(ledOut)
  );

  // Bench palette as {G,R,B}, written from the requirement table (R7).
  function automatic logic [23:0] expWord(input int idx);
    case (idx)
      0: return {8'd0, 8'd64, 8'd0};
      1: return {8'd64, 8'd0, 8'd0};
      2: return {8'd0, 8'd0, 8'd64};
      default: return {8'd64, 8'd0, 8'd64};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reset with new settings; checks pin low during reset and the first gap (R1).
  task automatic startRun(input int n, input int gap, input int slot,
                          input int h0, input int h1);
    int lows;
    @(negedge clk);
    rst = 1'b1;
    ledCount = 3'(n); gapCycles = 16'(gap); bitCycles = 16'(slot);
    zeroHighCycles = 16'(h0); oneHighCycles = 16'(h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(ledOut == 1'b0, "R1 pin low in reset", ledOut, 0);
    end
    rst = 1'b0;
    if (n == 0) return;
    lows = 0;
    @(negedge clk);
    while (!ledOut && lows < gap + 10) begin
      lows++;
      @(negedge clk);
    end
    check(lows == gap, "R1 first gap length", lows, gap);
  endtask

  // Decode one frame; entered at a negedge where the pin has just gone high.
  task automatic checkFrame(input int n, input int gap, input int slot,
                            input int h0, input int h1);
    int hi, lo, expH;
    bit expBit;
    for (int led = 0; led < n; led++) begin
      for (int b = 0; b < 24; b++) begin
        hi = 0;
        while (ledOut && hi < slot + 2) begin
          hi++;
          @(negedge clk);
        end
        expBit = expWord(led)[23 - b];
        expH = expBit ? h1 : h0;
        // R2 R3 pulse per bit value; R5 R6 R7 bit, LED and palette order
        check(hi == expH, $sformatf("R2 R3 R5 R6 R7 led%0d bit%0d high", led, b),
              hi, expH);
        lo = 0;
        while (!ledOut && lo < slot + gap + 10) begin
          lo++;
          @(negedge clk);
        end
        if (led == n - 1 && b == 23)
          check(lo == slot - hi + gap, "R8 inter-frame gap", lo, slot - hi + gap);
        else
          check(hi + lo == slot, "R4 bit slot length", hi + lo, slot);
      end
    end
  endtask

  task automatic testFullTiming();
    startRun(2, 28000, 125, 40, 80);
    checkFrame(2, 28000, 125, 40, 80);
    checkFrame(2, 28000, 125, 40, 80); // R8 restart at LED 0
  endtask

  task automatic testFourLeds();
    startRun(4, 50, 10, 3, 7); // R10 short timing
    checkFrame(4, 50, 10, 3, 7);
    checkFrame(4, 50, 10, 3, 7);
  endtask

  task automatic testOneLed();
    startRun(1, 40, 12, 2, 9); // R10
    checkFrame(1, 40, 12, 2, 9);
    checkFrame(1, 40, 12, 2, 9);
  endtask

  task automatic testEmptyChain();
    int highs;
    startRun(0, 20, 10, 3, 7);
    highs = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (ledOut) highs++;
    end
    check(highs == 0, "R9 empty chain stays low", highs, 0);
  endtask

  initial begin
    testFullTiming();
    testFourLeds();
    testOneLed();
    testEmptyChain();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule